// File: doc/BRIEF.md
# Channel Address Normalizer

This block converts a system physical address into the address seen by one memory channel. It removes a base offset from the address. The offset comes from one of three sources:

- the memory-hole relocation offset;
- the controller-select base offset, when the address falls in the high range;
- the DRAM range base.

Which source applies depends on the high-range flag, the hole enable and whether the address lies at or above 4 GiB. Both operands are aligned before the subtraction. The address is cut to a 64-byte line and the offset to an 8 MiB granule. The difference wraps within the 48-bit address space.

The same stage also decodes the node interleave field into a shift count. Later logic uses that count to squeeze interleave bits out of the channel address. A request is accepted on any cycle where `in_valid` is high. The result appears registered on the next cycle, with `out_valid` high. On cycles without a request, the result registers keep their last values.

Top module: `chan_addr_norm`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `chan_addr` and `intlv_shift` are all cleared to zero.
- R2: `out_valid` is high in exactly the cycles that follow a clock edge at which `in_valid` was high.
- R3: When `hi_range` is 0, `hole_en` is 1 and `sys_addr` >= 0x1_0000_0000, the offset is `hole_off` shifted left by 16 bits.
- R4: When `hi_range` is 0 and the R3 condition does not hold, the offset is `range_base` AND 0xFFFF_F800_0000.
- R5: When `hi_range` is 1 and the R6 condition does not hold, the offset is `sel_base_off`.
- R6: When `hi_range` is 1, `sel_base_upper` is zero, `hole_en` is 1 and `sys_addr` >= 0x1_0000_0000, the offset is `hole_off` shifted left by 16 bits.
- R7: `chan_addr` = (`sys_addr` AND 0xFFFF_FFFF_FFC0) minus (offset AND 0xFFFF_FF80_0000). As a result, the low 6 bits of `chan_addr` are always zero.
- R8: The subtraction wraps modulo 2^48. For example, address 0x40 minus range base 0x800_0000 gives 0xFFFF_F800_0040.
- R9: `intlv_shift` is 1 when `intlv_field` is 3'b001, 2 when it is 3'b011, 3 when it is 3'b111, and 0 for every other value.
- R10: On a clock edge where `in_valid` is low, `chan_addr` and `intlv_shift` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the inputs are sampled when it is high |
| sys_addr | input | 48 | System address to normalize |
| hi_range | input | 1 | Address lies in the controller-select high range |
| sel_base_upper | input | 16 | Upper half of the controller-select base address field |
| sel_base_off | input | 48 | Controller-select base offset |
| hole_en | input | 1 | Memory-hole remapping enabled |
| hole_off | input | 16 | Hole offset, applied shifted left by 16 |
| range_base | input | 48 | DRAM range base address |
| intlv_field | input | 3 | Node interleave enable field |
| out_valid | output | 1 | Registered result valid |
| chan_addr | output | 48 | Channel-relative address |
| intlv_shift | output | 2 | Interleave shift count |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid latency;
- the 64-byte alignment of every valid result;
- that the result registers hold when no request arrives;
- the interleave field decode.

Two offset-selection paths are also checked directly: the hole path with a zero offset, and the range-base path with a base below 128 MiB.

Some behaviour can only be shown by the bench's scenarios. These scenarios exercise:
- the full priority among the three offset sources;
- the exact 4 GiB boundary, both at the boundary and one byte under it;
- the effect of a non-zero upper select-base field in the high range;
- the coarse masking of an unaligned offset;
- the wrap below zero.

// File: rtl/chan_norm_pkg.sv
package chan_norm_pkg;

  typedef enum logic [1:0] {
    OFS_RANGE_BASE = 2'd0,
    OFS_SEL_BASE   = 2'd1,
    OFS_HOLE       = 2'd2
  } ofs_src_e;

  localparam int INTLV_W = 3;
  localparam int SHIFT_W = 2;

  // Interleave enable field to shift count: only contiguous masks shift.
  function automatic logic [SHIFT_W-1:0] intlv_to_shift(input logic [INTLV_W-1:0] f);
    logic [SHIFT_W-1:0] s;
    case (f)
      3'b001:  s = 2'd1;
      3'b011:  s = 2'd2;
      3'b111:  s = 2'd3;
      default: s = 2'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/cn_offset_sel.sv
module cn_offset_sel
  import chan_norm_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int SELUP_W    = 16,
  parameter int HOLE_W     = 16,
  parameter int HOLE_SHIFT = 16,
  parameter int BASE_LSB   = 27,
  parameter int LIMIT_BIT  = 32
) (
  input  logic [ADDR_W-1:0]  sys_addr,
  input  logic               hi_range,
  input  logic [SELUP_W-1:0] sel_base_upper,
  input  logic [ADDR_W-1:0]  sel_base_off,
  input  logic               hole_en,
  input  logic [HOLE_W-1:0]  hole_off,
  input  logic [ADDR_W-1:0]  range_base,
  output logic [ADDR_W-1:0]  offset,
  output ofs_src_e           src
);

  localparam int HOLE_PAD = ADDR_W - HOLE_W - HOLE_SHIFT;
  localparam logic [ADDR_W-1:0] BASE_MASK =
    {{(ADDR_W-BASE_LSB){1'b1}}, {BASE_LSB{1'b0}}};

  logic              above_limit;
  logic              hole_applies;
  logic [ADDR_W-1:0] hole_ofs;

  assign above_limit = |sys_addr[ADDR_W-1:LIMIT_BIT];
  assign hole_ofs    = {{HOLE_PAD{1'b0}}, hole_off, {HOLE_SHIFT{1'b0}}};

  // The high range only remaps through the hole when its select base sits low.
  always_comb begin
    if (hi_range)
      hole_applies = hole_en && above_limit && (sel_base_upper == '0);
    else
      hole_applies = hole_en && above_limit;
  end

  always_comb begin
    if (hole_applies)
      src = OFS_HOLE;
    else if (hi_range)
      src = OFS_SEL_BASE;
    else
      src = OFS_RANGE_BASE;
  end

  always_comb begin
    case (src)
      OFS_HOLE:     offset = hole_ofs;
      OFS_SEL_BASE: offset = sel_base_off;
      default:      offset = range_base & BASE_MASK;
    endcase
  end

endmodule

// File: rtl/cn_shift_map.sv
module cn_shift_map
  import chan_norm_pkg::*;
(
  input  logic [INTLV_W-1:0] intlv_field,
  output logic [SHIFT_W-1:0] shift
);

  assign shift = intlv_to_shift(intlv_field);

endmodule

// File: rtl/cn_sub_reg.sv
module cn_sub_reg
  import chan_norm_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int LINE_LSB   = 6,
  parameter int GRANULE_LSB = 23
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [ADDR_W-1:0]  sys_addr,
  input  logic [ADDR_W-1:0]  offset,
  input  logic [SHIFT_W-1:0] shift_in,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  chan_addr,
  output logic [SHIFT_W-1:0] intlv_shift
);

  localparam logic [ADDR_W-1:0] LINE_MASK =
    {{(ADDR_W-LINE_LSB){1'b1}}, {LINE_LSB{1'b0}}};
  localparam logic [ADDR_W-1:0] GRAN_MASK =
    {{(ADDR_W-GRANULE_LSB){1'b1}}, {GRANULE_LSB{1'b0}}};

  logic [ADDR_W-1:0] diff;

  // Width-limited subtract: borrow out of the top bit is dropped.
  assign diff = (sys_addr & LINE_MASK) - (offset & GRAN_MASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      chan_addr   <= '0;
      intlv_shift <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        chan_addr   <= diff;
        intlv_shift <= shift_in;
      end
    end
  end

endmodule

// File: rtl/chan_addr_norm.sv
module chan_addr_norm
  import chan_norm_pkg::*;
#(
  parameter int ADDR_W      = 48,
  parameter int SELUP_W     = 16,
  parameter int HOLE_W      = 16,
  parameter int HOLE_SHIFT  = 16,
  parameter int BASE_LSB    = 27,
  parameter int LIMIT_BIT   = 32,
  parameter int LINE_LSB    = 6,
  parameter int GRANULE_LSB = 23
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [ADDR_W-1:0]  sys_addr,
  input  logic               hi_range,
  input  logic [SELUP_W-1:0] sel_base_upper,
  input  logic [ADDR_W-1:0]  sel_base_off,
  input  logic               hole_en,
  input  logic [HOLE_W-1:0]  hole_off,
  input  logic [ADDR_W-1:0]  range_base,
  input  logic [INTLV_W-1:0] intlv_field,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  chan_addr,
  output logic [SHIFT_W-1:0] intlv_shift
);

  logic [ADDR_W-1:0]  offset;
  ofs_src_e           src;
  logic [SHIFT_W-1:0] shift_c;

  cn_offset_sel #(
    .ADDR_W(ADDR_W), .SELUP_W(SELUP_W), .HOLE_W(HOLE_W),
    .HOLE_SHIFT(HOLE_SHIFT), .BASE_LSB(BASE_LSB), .LIMIT_BIT(LIMIT_BIT)
  ) u_sel (
    .sys_addr(sys_addr), .hi_range(hi_range), .sel_base_upper(sel_base_upper),
    .sel_base_off(sel_base_off), .hole_en(hole_en), .hole_off(hole_off),
    .range_base(range_base), .offset(offset), .src(src)
  );

  cn_shift_map u_map (.intlv_field(intlv_field), .shift(shift_c));

  cn_sub_reg #(
    .ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB), .GRANULE_LSB(GRANULE_LSB)
  ) u_sub (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sys_addr(sys_addr),
    .offset(offset), .shift_in(shift_c), .out_valid(out_valid),
    .chan_addr(chan_addr), .intlv_shift(intlv_shift)
  );

endmodule

// File: rtl/chan_addr_norm_chk.sv
module chan_addr_norm_chk
  import chan_norm_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int HOLE_W   = 16,
  parameter int LINE_LSB = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [ADDR_W-1:0]  sys_addr,
  input logic               hi_range,
  input logic               hole_en,
  input logic [HOLE_W-1:0]  hole_off,
  input logic [ADDR_W-1:0]  range_base,
  input logic [INTLV_W-1:0] intlv_field,
  input logic               out_valid,
  input logic [ADDR_W-1:0]  chan_addr,
  input logic [SHIFT_W-1:0] intlv_shift
);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drops_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_line_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (chan_addr[LINE_LSB-1:0] == '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(chan_addr) && $stable(intlv_shift)));
  p_full_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && intlv_field == 3'b111) |=> (intlv_shift == 2'd3));
  p_noncontig_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && intlv_field != 3'b001 && intlv_field != 3'b011 && intlv_field != 3'b111)
      |=> (intlv_shift == 2'd0));
  // R3: a zero hole offset above 4 GiB in the low range leaves the line address intact
  p_zero_hole_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hi_range && hole_en && hole_off == '0 && (|sys_addr[ADDR_W-1:32]))
      |=> (chan_addr == {$past(sys_addr[ADDR_W-1:LINE_LSB]), {LINE_LSB{1'b0}}}));
  // R4: a range base below 128 MiB contributes nothing in the low range without the hole
  p_small_base_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !hi_range && !hole_en && range_base[ADDR_W-1:27] == '0)
      |=> (chan_addr == {$past(sys_addr[ADDR_W-1:LINE_LSB]), {LINE_LSB{1'b0}}}));

endmodule

bind chan_addr_norm chan_addr_norm_chk #(
  .ADDR_W(ADDR_W), .HOLE_W(HOLE_W), .LINE_LSB(LINE_LSB)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .sys_addr(sys_addr),
  .hi_range(hi_range), .hole_en(hole_en), .hole_off(hole_off),
  .range_base(range_base), .intlv_field(intlv_field), .out_valid(out_valid),
  .chan_addr(chan_addr), .intlv_shift(intlv_shift)
);

// File: tb/chan_addr_norm_test.sv
module chan_addr_norm_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [47:0] sys_addr;
  logic        hi_range;
  logic [15:0] sel_base_upper;
  logic [47:0] sel_base_off;
  logic        hole_en;
  logic [15:0] hole_off;
  logic [47:0] range_base;
  logic [2:0]  intlv_field;
  logic        out_valid;
  logic [47:0] chan_addr;
  logic [1:0]  intlv_shift;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  chan_addr_norm uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sys_addr(sys_addr),
    .hi_range(hi_range), .sel_base_upper(sel_base_upper),
    .sel_base_off(sel_base_off), .hole_en(hole_en), .hole_off(hole_off),
    .range_base(range_base), .intlv_field(intlv_field),
    .out_valid(out_valid), .chan_addr(chan_addr), .intlv_shift(intlv_shift)
  );

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drive one request, then sample the registered result one cycle later.
  task automatic issue(input logic [47:0] a, input logic hi, input logic [15:0] su,
                       input logic [47:0] so, input logic he, input logic [15:0] ho,
                       input logic [47:0] rb, input logic [2:0] il);
    @(negedge clk);
    in_valid = 1'b1; sys_addr = a; hi_range = hi; sel_base_upper = su;
    sel_base_off = so; hole_en = he; hole_off = ho; range_base = rb; intlv_field = il;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 out_valid", {47'b0, out_valid}, 48'h0);
    check("R1 chan_addr", chan_addr, 48'h0);
    check("R1 intlv_shift", {46'b0, intlv_shift}, 48'h0);
  endtask

  task automatic t_low_hole;
    issue(48'h1_2345_6789, 1'b0, 16'h0, 48'h0, 1'b1, 16'h0080, 48'h0, 3'b000);
    check("R2 out_valid", {47'b0, out_valid}, 48'h1);
    check("R3 hole offset", chan_addr, 48'h1_22C5_6780);
    issue(48'h1_0000_0000, 1'b0, 16'h0, 48'h0, 1'b1, 16'h0100, 48'h0, 3'b000);
    check("R3 exact 4GiB", chan_addr, 48'h0_FF00_0000);
  endtask

  task automatic t_low_base;
    issue(48'h0_FFFF_FFFF, 1'b0, 16'h0, 48'h0, 1'b1, 16'h0100, 48'h0_1FFF_FFFF, 3'b000);
    check("R4 below 4GiB base", chan_addr, 48'h0_E7FF_FFC0);
    issue(48'h2_0000_0000, 1'b0, 16'h0, 48'h0, 1'b0, 16'h0100, 48'h1_0000_0000, 3'b000);
    check("R4 hole disabled", chan_addr, 48'h1_0000_0000);
  endtask

  task automatic t_high;
    issue(48'h3_0000_0000, 1'b1, 16'h0001, 48'h1_0040_0000, 1'b1, 16'h0200, 48'h0, 3'b000);
    check("R5 select base offset", chan_addr, 48'h2_0000_0000);
    issue(48'h3_0000_0000, 1'b1, 16'h0000, 48'h1_0040_0000, 1'b1, 16'h0200, 48'h0, 3'b000);
    check("R6 high-range hole", chan_addr, 48'h2_FE00_0000);
    issue(48'h0_8000_0000, 1'b1, 16'h0000, 48'h0_4000_0000, 1'b1, 16'h0200, 48'h0, 3'b000);
    check("R5 high below 4GiB", chan_addr, 48'h0_4000_0000);
  endtask

  task automatic t_mask_wrap;
    issue(48'h0_1234_567F, 1'b1, 16'h1, 48'h0_007F_FFFF, 1'b0, 16'h0, 48'h0, 3'b000);
    check("R7 masks", chan_addr, 48'h0_1234_5640);
    issue(48'h0_0000_0040, 1'b0, 16'h0, 48'h0, 1'b0, 16'h0, 48'h0_0800_0000, 3'b000);
    check("R8 wrap", chan_addr, 48'hFFFF_F800_0040);
  endtask

  task automatic t_shift;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] e;
      e = (i == 1) ? 2'd1 : (i == 3) ? 2'd2 : (i == 7) ? 2'd3 : 2'd0;
      issue(48'h0, 1'b0, 16'h0, 48'h0, 1'b0, 16'h0, 48'h0, 3'(i));
      check("R9 shift map", {46'b0, intlv_shift}, {46'b0, e});
    end
  endtask

  task automatic t_hold;
    issue(48'h5_5555_5540, 1'b0, 16'h0, 48'h0, 1'b0, 16'h0, 48'h0, 3'b011);
    @(negedge clk);
    sys_addr = 48'h0_0000_1000; range_base = 48'hFFFF_0000_0000; intlv_field = 3'b111;
    @(negedge clk);
    check("R2 valid low", {47'b0, out_valid}, 48'h0);
    check("R10 addr held", chan_addr, 48'h5_5555_5540);
    check("R10 shift held", {46'b0, intlv_shift}, 48'h2);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; sys_addr = '0; hi_range = 1'b0;
    sel_base_upper = '0; sel_base_off = '0; hole_en = 1'b0; hole_off = '0;
    range_base = '0; intlv_field = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_low_hole();
    t_low_base();
    t_high();
    t_mask_wrap();
    t_shift();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule